// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervisory down-counter for a processor subsystem. Software programs a start value, picks a response mode and a reset pulse length, and then turns the watchdog on. From then on the counter moves down by one on each cycle where the external count strobe is high and the pause input is low. Software must write a fixed key to the restart register often enough to keep the counter from running out.

When the counter runs out, the block acts according to the response mode. In direct mode it issues a system reset pulse at once. In two-stage mode the first run-out raises an interrupt and reloads the counter. A second run-out with no restart in between issues the reset pulse. Clearing the interrupt does not prevent this second stage.

Once the watchdog is on, software cannot turn it off or change its mode. All registers can be read through a registered read port, and reads have no side effects.

Top module: `wdg_top`

## Requirements
- R1: After reset the watchdog is off, the counter is 0, `irq` and `sys_rst` are low, and every register reads 0.
- R2: A write to CTRL (address 1) with bit 0 set while the watchdog is off turns it on and loads the counter from LOAD (address 0, which holds the start value in its low CNT_W bits).
- R3: While the watchdog is on, the counter drops by one only on cycles with `cnt_en` high and `pause` low. While the watchdog is off, the counter never moves.
- R4: While `pause` is high, the counter holds its value even when `cnt_en` is high.
- R5: The counter runs out on a counting cycle in which it holds 1 or 0, and it is then reloaded from LOAD. In direct mode (CTRL bit 1 = 0), `sys_rst` goes high from the next cycle and stays high for 2 << CTRL[3:2] cycles (2, 4, 8 or 16).
- R6: In two-stage mode (CTRL bit 1 = 1), the first run-out sets `irq` and arms the second stage. The next run-out with no valid restart in between issues the reset pulse, even if `irq` was cleared. A reset pulse clears `irq` and the armed stage. In direct mode `irq` never rises.
- R7: A write of exactly 0x0076 to RESTART (address 2) reloads the counter from LOAD and clears the armed stage. Any other value has no effect. A valid restart wins over a run-out in the same cycle.
- R8: Once the watchdog is on, writes to CTRL have no effect. Bit 0 cannot be cleared, and the mode and pulse-length fields are locked.
- R9: Any write to IRQCLR (address 3) clears `irq`. It leaves the counter and the armed stage unchanged. A new first-stage run-out in the same cycle wins over the clear.
- R10: When `rd_en` is high, `rdata` shows the addressed register on the next cycle and holds otherwise. The read map is:
  - 0: LOAD
  - 1: CTRL
  - 4: STATUS, with bit 0 = irq, bit 1 = on, bit 2 = stage armed, bit 3 = pulse active
  - 5: the live count
  - all other addresses: 0

  Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cnt_en | input | 1 | Count strobe; one decrement per high cycle |
| pause | input | 1 | Freezes the counter while high |
| irq | output | 1 | First-stage interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
The assertions take for granted that `wr_en` and `rd_en` are plain synchronous strobes and that `addr` and `wdata` are stable while the strobes are high. They also assume `cnt_en` and `pause` are synchronous to `clk`, and that the system reset does not feed back into `rst_n` during a run. The stimulus drives every input on the falling edge, holds it for a whole cycle, and never loops `sys_rst` back into reset. Phases that need a different mode begin with a fresh `rst_n` pulse rather than a CTRL rewrite, because CTRL is locked once the watchdog is on.

// File: rtl/wdg_pkg.sv
// Shared constants for the watchdog: register addresses, control field
// positions and the restart key. Assumes a 3-bit register address.
package wdg_pkg;
    localparam int ADDR_W   = 3;
    localparam int SEL_W    = 2;
    localparam int KEY_VAL  = 'h76;
    localparam int CTRL_ON  = 0;
    localparam int CTRL_MD  = 1;
    localparam int CTRL_SEL = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD = 3'd0,
        REG_CTRL = 3'd1,
        REG_KICK = 3'd2,
        REG_ICLR = 3'd3,
        REG_STAT = 3'd4,
        REG_CNT  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/wdg_regs.sv
// Register front end: holds LOAD and CTRL, decodes restart and interrupt-clear
// writes, and drives the registered read port. Assumes DATA_W >= CNT_W and
// DATA_W >= 8. CTRL is write-once: it is locked as soon as the on bit is set.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    input  logic              stage_i,
    input  logic              pulse_i,
    output logic              on_o,
    output logic              mode_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              reload_o,
    output logic              kick_o,
    output logic              iclr_o
);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY_VAL);

    reg_addr_e   a_e;
    logic        ctrl_wr;
    logic        turn_on;

    assign a_e      = reg_addr_e'(addr);
    assign ctrl_wr  = wr_en && (a_e == REG_CTRL) && !on_o;
    assign turn_on  = ctrl_wr && wdata[CTRL_ON];
    assign kick_o   = wr_en && (a_e == REG_KICK) && (wdata == KEY_W);
    assign iclr_o   = wr_en && (a_e == REG_ICLR);
    assign reload_o = kick_o || turn_on;

    // Start value storage; writable at any time, used at the next reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_o <= '0;
        else if (wr_en && (a_e == REG_LOAD))
            load_o <= wdata[CNT_W-1:0];
    end

    // Control storage; accepts writes only while the watchdog is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_o   <= 1'b0;
            mode_o <= 1'b0;
            sel_o  <= '0;
        end else if (ctrl_wr) begin
            on_o   <= wdata[CTRL_ON];
            mode_o <= wdata[CTRL_MD];
            sel_o  <= wdata[CTRL_SEL +: SEL_W];
        end
    end

    // Registered read port; a read only samples state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            case (a_e)
                REG_LOAD: rdata <= DATA_W'(load_o);
                REG_CTRL: rdata <= DATA_W'({sel_o, mode_o, on_o});
                REG_STAT: rdata <= DATA_W'({pulse_i, stage_i, on_o, irq_i});
                REG_CNT:  rdata <= DATA_W'(cnt_i);
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wdg_counter.sv
// Down-counter core: decrements on qualified strobes, reloads on request or
// on run-out, and flags a run-out when a step is taken at 1 or 0.
// Assumes cnt_en and pause are synchronous to clk.
module wdg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic             cnt_en,
    input  logic             pause,
    input  logic             reload,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step   = on && cnt_en && !pause;
    assign expire = step && (cnt <= ONE);

    // Count state: explicit reload first, then run-out reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload || expire)
            cnt <= load;
        else if (step)
            cnt <= cnt - ONE;
    end
endmodule

// File: rtl/wdg_response.sv
// Run-out response: tracks the armed second stage and the interrupt, and
// stretches a reset trigger into a pulse of 2 << sel cycles.
// Assumes sel is held stable while the watchdog is on.
module wdg_response
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic [SEL_W-1:0] sel,
    input  logic             expire,
    input  logic             kick,
    input  logic             iclr,
    output logic             irq,
    output logic             stage,
    output logic             sys_rst
);
    localparam int PLS_W = (1 << SEL_W) + 1;

    logic             fire;
    logic             first;
    logic [PLS_W-1:0] pls_cnt;

    assign first   = expire && !kick && mode && !stage;
    assign fire    = expire && !kick && (!mode || stage);
    assign sys_rst = (pls_cnt != '0);

    // Armed-stage flag: set by a first-stage run-out, cleared by restart or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= 1'b0;
        else if (kick || fire)
            stage <= 1'b0;
        else if (first)
            stage <= 1'b1;
    end

    // Interrupt flag: reset pulse clears, first stage sets, software clear last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (fire)
            irq <= 1'b0;
        else if (first)
            irq <= 1'b1;
        else if (iclr)
            irq <= 1'b0;
    end

    // Pulse stretcher: loads the selected length on a trigger, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pls_cnt <= '0;
        else if (fire)
            pls_cnt <= PLS_W'(2) << sel;
        else if (pls_cnt != '0)
            pls_cnt <= pls_cnt - PLS_W'(1);
    end
endmodule

// File: rtl/wdg_top.sv
// Two-stage watchdog top: joins the register front end, the counter core and
// the run-out response. Assumes a single clock and synchronous active-low reset.
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cnt_en,
    input  logic              pause,
    output logic              irq,
    output logic              sys_rst
);
    logic             on;
    logic             mode;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] cnt;
    logic             reload;
    logic             kick;
    logic             iclr;
    logic             expire;
    logic             stage;

    wdg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cnt_i(cnt), .irq_i(irq), .stage_i(stage), .pulse_i(sys_rst),
        .on_o(on), .mode_o(mode), .sel_o(sel), .load_o(load),
        .reload_o(reload), .kick_o(kick), .iclr_o(iclr)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .on(on), .cnt_en(cnt_en), .pause(pause),
        .reload(reload), .load(load), .cnt(cnt), .expire(expire)
    );

    wdg_response u_resp (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .expire(expire),
        .kick(kick), .iclr(iclr), .irq(irq), .stage(stage), .sys_rst(sys_rst)
    );
endmodule

// File: rtl/wdg_checker.sv
// Property checker for wdg_top, attached by bind. Observes the control
// state, the counter and the outputs; drives nothing.
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             on,
    input logic             mode,
    input logic [SEL_W-1:0] sel,
    input logic [CNT_W-1:0] cnt,
    input logic             expire,
    input logic             kick,
    input logic             stage,
    input logic             pause,
    input logic             irq,
    input logic             sys_rst
);
    // R8: the on bit never falls once set.
    assert_on_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        on |=> on);

    // R8: the mode and length fields stay fixed while on.
    assert_ctrl_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        on |=> ($stable(mode) && $stable(sel)));

    // R4: pause freezes the count unless a valid restart arrives.
    assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (on && pause && !kick) |=> (cnt == $past(cnt)));

    // R3: with the watchdog off and no writes, the count does not move.
    assert_idle_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && !wr_en) |=> (cnt == $past(cnt)));

    // R5: a reset pulse starts only after a run-out.
    assert_rst_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(expire));

    // R6: direct mode never raises the interrupt.
    assert_no_irq_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !irq);

    // R6: a run-out with the stage armed and no restart yields a reset pulse.
    assert_second_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stage && !kick) |=> sys_rst);

    // R7: a valid restart always disarms the second stage.
    assert_kick_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !stage);
endmodule

bind wdg_top wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .on(on), .mode(mode), .sel(sel),
    .cnt(cnt), .expire(expire), .kick(kick), .stage(stage), .pause(pause),
    .irq(irq), .sys_rst(sys_rst)
);

// File: tb/tb_wdg_top.sv
// Bench for wdg_top: a behavioural reference model stepped on every rising
// edge and compared on every falling edge, plus directed scenario checks.
module tb_wdg_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          cnt_en = 1'b0;
    logic          pause = 1'b0;
    logic          irq;
    logic          sys_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit run = 0;

    always #2 clk = ~clk;

    wdg_top #(.CNT_W(16), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .pause(pause),
        .irq(irq), .sys_rst(sys_rst)
    );

    // Reference model state
    int m_cnt, m_load, m_on, m_mode, m_sel, m_irq, m_stage, m_pls, m_rd;

    function automatic int m_read(int a);
        case (a)
            0: return m_load;
            1: return m_on | (m_mode << 1) | (m_sel << 2);
            4: return m_irq | (m_on << 1) | (m_stage << 2) | ((m_pls != 0) << 3);
            5: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_on = 0; m_mode = 0; m_sel = 0;
            m_irq = 0; m_stage = 0; m_pls = 0; m_rd = 0;
        end else begin
            int kick, iclr, onw, step, to, fire, first, n_cnt, n_pls;
            kick  = wr_en && addr == 2 && wdata == 16'h0076;
            iclr  = wr_en && addr == 3;
            onw   = wr_en && addr == 1 && !m_on && wdata[0];
            step  = m_on && cnt_en && !pause;
            to    = step && m_cnt <= 1;
            fire  = to && !kick && (!m_mode || m_stage);
            first = to && !kick && m_mode && !m_stage;
            if (rd_en) m_rd = m_read(addr);
            if (kick || onw || to) n_cnt = m_load;
            else if (step) n_cnt = m_cnt - 1;
            else n_cnt = m_cnt;
            if (fire) n_pls = 2 << m_sel;
            else if (m_pls > 0) n_pls = m_pls - 1;
            else n_pls = 0;
            if (fire) m_irq = 0;
            else if (first) m_irq = 1;
            else if (iclr) m_irq = 0;
            if (kick || fire) m_stage = 0;
            else if (first) m_stage = 1;
            if (wr_en && addr == 1 && !m_on) begin
                m_on = wdata[0]; m_mode = wdata[1]; m_sel = wdata[3:2];
            end
            if (wr_en && addr == 0) m_load = wdata;
            m_cnt = n_cnt;
            m_pls = n_pls;
        end
    end

    task automatic chk(string req, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R5 sys_rst vs model", sys_rst, m_pls != 0);
            chk("R6 irq vs model", irq, m_irq);
            chk("R10 rdata vs model", rdata, m_rd);
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1; addr = 3'(a); wdata = DW'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a, output int v);
        rd_en = 1; addr = 3'(a);
        @(negedge clk);
        rd_en = 0;
        v = rdata;
    endtask

    task automatic tick(int n);
        cnt_en = 1;
        repeat (n) @(negedge clk);
        cnt_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (sys_rst === 1'b1 && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int v, v2, n;
        @(negedge clk);
        run = 1;
        do_reset();
        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 sys_rst", sys_rst, 0);
        rd(1, v); chk("R1 CTRL", v, 0);
        rd(5, v); chk("R1 count", v, 0);
        // R3: no counting while off
        tick(3);
        rd(5, v); chk("R3 count while off", v, 0);
        // R2: enabling loads the counter (direct mode, 8-cycle pulse)
        wr(0, 5);
        wr(1, 'h9);
        rd(5, v); chk("R2 count after enable", v, 5);
        // R3: three strobes
        tick(3);
        rd(5, v); chk("R3 count after 3 steps", v, 2);
        // R10: repeated reads do not disturb
        rd(5, v); rd(5, v2);
        chk("R10 reread count", v2, 2);
        rd(0, v); chk("R10 LOAD readback", v, 5);
        // R4: pause holds
        pause = 1; tick(4); pause = 0;
        rd(5, v); chk("R4 count under pause", v, 2);
        // R8: cannot disable or reconfigure
        wr(1, 'h6);
        rd(1, v); chk("R8 CTRL locked", v, 'h9);
        // R7: wrong key ignored, right key reloads
        wr(2, 'h75);
        rd(5, v); chk("R7 bad key ignored", v, 2);
        wr(2, 'h176);
        rd(5, v); chk("R7 key with extra bits ignored", v, 2);
        wr(2, 'h76);
        rd(5, v); chk("R7 good key reloads", v, 5);
        // R9: clear has no effect on the count
        wr(3, 0);
        rd(5, v); chk("R9 clear keeps count", v, 5);
        // R5: direct run-out, 8-cycle pulse
        tick(4);
        chk("R5 no reset before run-out", sys_rst, 0);
        tick(1);
        pulse_len(n); chk("R5 pulse length sel=2", n, 8);
        chk("R6 no irq in direct mode", irq, 0);
        rd(5, v); chk("R5 reload after run-out", v, 5);

        // Two-stage mode, 2-cycle pulse
        do_reset();
        wr(0, 3);
        wr(1, 'h3);
        tick(3);
        chk("R6 first stage irq", irq, 1);
        chk("R6 first stage no reset", sys_rst, 0);
        rd(5, v); chk("R6 reload after first stage", v, 3);
        wr(3, 0);
        chk("R9 irq cleared", irq, 0);
        rd(4, v); chk("R9 stage kept after clear", v, 6);
        tick(3);
        pulse_len(n); chk("R6 second stage pulse sel=0", n, 2);
        rd(4, v); chk("R6 status after reset pulse", v, 2);
        // R7: restart between stages disarms
        tick(3);
        chk("R6 irq again", irq, 1);
        wr(2, 'h76);
        tick(3);
        chk("R7 no reset after restart", sys_rst, 0);
        rd(4, v); chk("R7 status re-armed", v, 7);
        // R7: restart wins over a simultaneous run-out
        tick(2);
        cnt_en = 1; wr(2, 'h76); cnt_en = 0;
        chk("R7 restart beats run-out", sys_rst, 0);
        rd(4, v); chk("R7 stage cleared", v, 3);
        rd(5, v); chk("R7 count reloaded", v, 3);
        repeat (4) @(negedge clk);
        chk("R7 still no reset", sys_rst, 0);
        finish_up();
    end
endmodule